// File: doc/BRIEF.md
# Reference Clock Deglitcher and Frequency Race Detector

This block conditions an external speed reference clock and compares its rate with a tachometer feedback signal from a motor. Both raw inputs are first brought into the system clock domain by a short synchronizer chain. A two-sample agreement filter then removes glitches: a level must be seen on two consecutive system clock edges before the filtered output takes it. The filtered reference is also driven out for use elsewhere.

The filtered rising edges of the reference and of the feedback compete in a phase/frequency-detector style race. A reference edge raises `up` and a feedback edge raises `down`. When the second flag would also be set, both flags clear instead. If the reference runs faster, `up` is high for most of the time. If the feedback runs faster, `down` is high for most of the time. If the reference stops while feedback edges keep arriving, `down` keeps being asserted, and `up` is never raised without reference edges. Feedback rates of a few kilohertz (feedback frequency = RPM × poles / 120, up to roughly 6.7 kHz) are many thousands of system clock periods long and pose no limit.

Top module: `freq_race_detector`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ref_clean`, `up` and `down` are 0.
- R2: A level on `ref_in` that is sampled by only one rising `clk` edge never reaches `ref_clean`.
- R3: A new level on `ref_in` that is sampled by at least two consecutive rising `clk` edges appears on `ref_clean` after the fourth rising edge that samples it, and not earlier.
- R4: When `down` is 0, a filtered rising edge of `ref_in` sets `up` one edge after `ref_clean` rises (fifth sampling edge). Once set, `up` stays 1 until a feedback edge arrives.
- R5: When `up` is 0, a filtered rising edge of `fb_in` sets `down` after the fifth rising edge that samples it. Once set, `down` stays 1 until a reference edge arrives.
- R6: `up` and `down` are never 1 together. An edge that would set the second flag clears both. Edges arriving together on both inputs leave both at 0.
- R7: With no transitions on `ref_in`, `up` never becomes 1, even while `fb_in` toggles.
- R8: With the reference quiet and feedback edges arriving, `down` is 1.
- R9: The feedback path filters glitches the same way: a one-sample `fb_in` pulse does not set `down`, and a two-sample pulse does.
- R10: Falling edges on either input have no effect on `up` or `down`.
- R11: A reference at twice the feedback rate keeps `up` high for more cycles than `down`. The reverse ratio keeps `down` high for more cycles than `up`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Raw speed reference clock |
| fb_in | input | 1 | Raw tachometer feedback signal |
| ref_clean | output | 1 | Synchronized, deglitched reference |
| up | output | 1 | Reference is ahead |
| down | output | 1 | Feedback is ahead |

## Verification
The hardest case to reach from the ports is a reference edge and a feedback edge leaving the filters on the same system clock cycle. Only in that case are both flags requested together, and it must leave both outputs low. The bench produces it by driving both raw inputs from the same falling clock edge with identical waveforms. This gives the two inputs the same path latency, so every detected edge coincides. The bench also places pulses exactly one and two samples wide to bracket the filter threshold on each input.

// File: rtl/freq_race_detector.sv
module freq_race_detector #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic ref_clean,
  output logic up,
  output logic down
);

  localparam int CH = 2;

  logic [CH-1:0] raw, synced, clean, rise;
  logic up_q, dn_q;

  assign raw = {fb_in, ref_in};

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [SYNC_STAGES-1:0] sh;
    logic hold_q, clean_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh      <= '0;
        hold_q  <= 1'b0;
        clean_q <= 1'b0;
        prev_q  <= 1'b0;
      end else begin
        sh      <= {sh[SYNC_STAGES-2:0], raw[g]};
        hold_q  <= sh[SYNC_STAGES-1];
        prev_q  <= clean_q;
        if (sh[SYNC_STAGES-1] == hold_q)
          clean_q <= hold_q;
      end
    end

    assign synced[g] = sh[SYNC_STAGES-1];
    assign clean[g]  = clean_q;
    assign rise[g]   = clean_q & ~prev_q;
  end

  wire ref_rise = rise[0];
  wire fb_rise  = rise[1];
  wire up_n     = up_q | ref_rise;
  wire dn_n     = dn_q | fb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_n && dn_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  assign ref_clean = clean[0];
  assign up        = up_q;
  assign down      = dn_q;

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && down));

  assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clean) |-> $past(synced[0], 1) && $past(synced[0], 2));

  assert_up_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(ref_rise) && !$past(fb_rise));

  assert_down_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down) |-> $past(fb_rise) && !$past(ref_rise));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_rise) |-> !$rose(up));

endmodule

// File: tb/test_freq_race_detector.sv
module test_freq_race_detector;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic ref_clean, up, down;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  freq_race_detector i_freq_race_detector (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .ref_clean(ref_clean), .up(up), .down(down)
  );

  // {channel (0 ref, 1 fb), pulse width in samples, expected to pass}
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 6'd1, 1'b0},  // R2
    {1'b0, 6'd2, 1'b1},  // R3
    {1'b0, 6'd3, 1'b1},
    {1'b0, 6'd9, 1'b1},
    {1'b1, 6'd1, 1'b0},  // R9
    {1'b1, 6'd2, 1'b1},
    {1'b1, 6'd4, 1'b1},
    {1'b0, 6'd1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_waves(input int rp, input int fp, input int n,
                           output int up_c, output int dn_c, output int both);
    up_c = 0; dn_c = 0; both = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (up) up_c++;
      if (down) dn_c++;
      if (up && down) both++;
      ref_in = rp > 0 ? ((t % rp) < rp / 2) : 1'b0;
      fb_in  = fp > 0 ? ((t % fp) < fp / 2) : 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int uc, dc, bc, seen;
    // R1
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {ref_clean, up, down}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ref_clean, up, down}, 0);

    // table of filter pulses
    for (int i = 0; i < 8; i++) begin
      do_reset();
      @(negedge clk);
      if (VEC[i][7]) fb_in = 1'b1; else ref_in = 1'b1;
      repeat (VEC[i][6:1]) @(negedge clk);
      ref_in = 1'b0; fb_in = 1'b0;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (VEC[i][7] ? down : ref_clean) seen = 1;
      end
      chk(VEC[i][7] ? "R9 fb filter" : "R2/R3 ref filter", seen, int'(VEC[i][0]));
    end

    // R3 latency and R4 up timing
    do_reset();
    @(negedge clk); ref_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 not yet", ref_clean, 0);
    @(negedge clk);
    chk("R3 latency", ref_clean, 1);
    chk("R4 up not yet", up, 0);
    @(negedge clk);
    chk("R4 up set", up, 1);
    // R10 falling edge ignored
    ref_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 up after falling ref", {up, down}, 2);
    // R6 feedback edge clears both
    fb_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 clear both", {up, down}, 0);
    fb_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 after falling fb", {up, down}, 0);

    // R5 down timing
    do_reset();
    @(negedge clk); fb_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 down not yet", down, 0);
    @(negedge clk);
    chk("R5 down set", down, 1);
    fb_in = 1'b0;

    // R7 / R8 reference quiet, feedback running
    do_reset();
    run_waves(0, 16, 400, uc, dc, bc);
    chk("R7 up never high", uc, 0);
    chk("R8 down high", down, 1);

    // R11 reference faster
    do_reset();
    run_waves(20, 40, 2000, uc, dc, bc);
    chk("R11 up dominates", int'(uc > dc), 1);
    chk("R6 exclusive fast ref", bc, 0);

    // R11 feedback faster
    do_reset();
    run_waves(40, 20, 2000, uc, dc, bc);
    chk("R11 down dominates", int'(dc > uc), 1);

    // R6 coincident edges
    do_reset();
    run_waves(24, 24, 1000, uc, dc, bc);
    chk("R6 coincident up", uc, 0);
    chk("R6 coincident down", dc, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule